// File: doc/BRIEF.md
# Vector Element Predicate Generator

This block walks a vector loop of VL elements and, for each element, tells the execution side whether the destination write and the source read of that element are enabled. A loop begins with a one-cycle start pulse. On that pulse the block captures the loop length, the mask configuration and three 64-bit integer predicate registers. It then presents element indices 0 to VL-1 in order, one per cycle while the consumer's ready input is high. When the loop is complete it raises a one-cycle done pulse.

Each enable is produced by an 8-way mask code, and a shared mode bit picks one of two families. In the integer family the code chooses one of three registers (R3, R10, R30), plain or inverted, or it enables only the element whose index equals R3, or it enables every element. In the condition family the code picks one flag of a 4-bit condition field and tests it for set or clear. That field is fetched from an external bank at a fixed base of 32 plus the element index, in the same cycle the element is presented. A second code with the same encoding drives the source enable when twin predication is on.

Top module: `vec_pred_gen`

## Requirements
- R1: With mode bit 0 and destination code 000, every presented element has its destination enable at 1.
- R2: With mode bit 0 and code 001, an element is enabled only when its index equals the full 64-bit value of R3. A value of R3 at or above VL enables nothing.
- R3: With mode bit 0, codes 010/011 enable element i when bit i of R3 is set/clear, 100/101 do the same with R10, and 110/111 with R30. All three registers are captured on the accepted start, so later changes on their inputs have no effect on a running loop.
- R4: With mode bit 1, the condition field holds its flags as bit 3 = less-than, bit 2 = greater-than, bit 1 = equal, bit 0 = summary-overflow. Codes 000..111 test, in that order, bit 3 set, bit 3 clear, bit 2 set, bit 2 clear, bit 1 set, bit 1 clear, bit 0 set, bit 0 clear.
- R5: While element i is presented, the condition-field address output equals 32 + i and the field data is used in that same cycle. A change to the bank after the start still affects elements not yet reached.
- R6: When twin predication is on, the source enable uses the source code with the encoding of R1–R4 under the shared mode bit. When it is off, the source enable is 1 for every presented element.
- R7: Elements are presented in index order 0 to VL-1 with the element-valid output high. The index advances on a clock edge where ready is high and holds, still valid, while ready is low. Both enables are 0 when no element is presented.
- R8: A start with VL = 0 presents no element and gives the done pulse in the cycle after the start.
- R9: The done pulse lasts one cycle and comes in the cycle after the last element is accepted. Busy is high from the cycle after the start through the done cycle and low in the cycle after done.
- R10: A start pulse that arrives while busy is high, including during the done cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Loop start pulse |
| vlIn | input | 7 | Loop length, 0 to 64 |
| readyIn | input | 1 | Consumer accepts the presented element |
| maskModeIn | input | 1 | 0 = integer family, 1 = condition family |
| dstCodeIn | input | 3 | Destination mask code |
| srcCodeIn | input | 3 | Source mask code |
| twinIn | input | 1 | Twin predication on |
| r3In | input | 64 | Integer predicate register R3 |
| r10In | input | 64 | Integer predicate register R10 |
| r30In | input | 64 | Integer predicate register R30 |
| crDataIn | input | 4 | Condition field read from the bank |
| crAddrOut | output | 7 | Condition field address |
| elemValidOut | output | 1 | An element is presented |
| elemIdxOut | output | 6 | Index of the presented element |
| dstEnOut | output | 1 | Destination enable |
| srcEnOut | output | 1 | Source enable |
| doneOut | output | 1 | Loop finished pulse |
| busyOut | output | 1 | Loop in progress |

## Verification
Two events can land in the same cycle: a stray start pulse and loop progress. One case is a start during a running element, with ready either high or low. The other is a start during the done cycle itself. The bench raises start at both points. Its model predicts that the index keeps stepping undisturbed and that busy falls right after done and stays low. A comparison every cycle against this model catches any restart. The bench also rewrites the condition bank and the integer register inputs in the middle of a loop. This checks that the condition fields are read lazily while the registers stay captured.

// File: rtl/predgen_pkg.sv
package predgen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } loopState_e;

  // Strobes from the loop control to the datapath
  typedef struct packed {
    logic load;    // capture configuration (accepted start)
    logic active;  // an element is presented this cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/predgen_ctrl.sv
module predgen_ctrl
  import predgen_pkg::*;
#(
  parameter int VL_MAX = 64,
  localparam int IDX_W = $clog2(VL_MAX),
  localparam int VL_W  = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [VL_W-1:0]  vlIn,
  input  logic             readyIn,
  output ctrlStrobes_t     strobesOut,
  output logic [IDX_W-1:0] idxOut,
  output logic             elemValidOut,
  output logic             doneOut,
  output logic             busyOut
);

  localparam logic [VL_W-1:0] VL_LIMIT = VL_W'(VL_MAX);

  loopState_e       state;
  logic [IDX_W-1:0] idx;
  logic [VL_W-1:0]  vlReg;
  logic [VL_W-1:0]  vlClamped;
  logic             accept;
  logic             isLast;
  logic             loadNow;

  always_comb begin
    vlClamped    = (vlIn > VL_LIMIT) ? VL_LIMIT : vlIn;
    elemValidOut = (state == ST_RUN);
    accept       = elemValidOut && readyIn;
    isLast       = ({1'b0, idx} == (vlReg - VL_W'(1)));
    loadNow      = (state == ST_IDLE) && startIn;
    doneOut      = (state == ST_DONE);
    busyOut      = (state != ST_IDLE);
    idxOut       = idx;
    strobesOut.load   = loadNow;
    strobesOut.active = elemValidOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      vlReg <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startIn) begin
            vlReg <= vlClamped;
            idx   <= '0;
            state <= (vlClamped == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (accept) begin
            if (isLast) state <= ST_DONE;
            else        idx   <= idx + IDX_W'(1);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: presented index stays below the captured loop length
  p_idx_in_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    elemValidOut |-> ({1'b0, idxOut} < vlReg));

  // R7: a stalled element is held
  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    (elemValidOut && !readyIn) |=> (elemValidOut && $stable(idxOut)));

  // R7: an accepted non-final element moves to the next index
  p_advance_r7: assert property (@(posedge clk) disable iff (!rstN)
    (elemValidOut && readyIn && !isLast) |=>
      (elemValidOut && (idxOut == IDX_W'($past(idxOut) + 1'b1))));

  // R9: done follows acceptance of the last element
  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rstN)
    (elemValidOut && readyIn && isLast) |=> doneOut);

  // R9: done is a single-cycle pulse, then busy drops
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> (!doneOut && !busyOut));

  // R8: zero-length loop goes straight to done
  p_zero_vl_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busyOut && startIn && (vlIn == '0)) |=> (doneOut && !elemValidOut));

  // R10: a start during a stalled element does not restart the loop
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (elemValidOut && startIn && !readyIn) |=> (elemValidOut && $stable(idxOut)));

endmodule

// File: rtl/predgen_lane.sv
module predgen_lane #(
  parameter int REG_W = 64,
  parameter int IDX_W = 6
) (
  input  logic             maskMode,
  input  logic [2:0]       code,
  input  logic [REG_W-1:0] regA,   // R3
  input  logic [REG_W-1:0] regB,   // R10
  input  logic [REG_W-1:0] regC,   // R30
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       crField,
  output logic             enOut
);

  logic [REG_W-1:0] idxWide;
  logic             crBit;

  always_comb begin
    idxWide = {{(REG_W-IDX_W){1'b0}}, idx};
    unique case (code[2:1])
      2'd0:    crBit = crField[3];
      2'd1:    crBit = crField[2];
      2'd2:    crBit = crField[1];
      default: crBit = crField[0];
    endcase
    if (maskMode) begin
      enOut = crBit ^ code[0];
    end else begin
      unique case (code)
        3'd0:    enOut = 1'b1;
        3'd1:    enOut = (regA == idxWide);
        3'd2:    enOut = regA[idx];
        3'd3:    enOut = ~regA[idx];
        3'd4:    enOut = regB[idx];
        3'd5:    enOut = ~regB[idx];
        3'd6:    enOut = regC[idx];
        default: enOut = ~regC[idx];
      endcase
    end
  end

endmodule

// File: rtl/predgen_dp.sv
module predgen_dp
  import predgen_pkg::*;
#(
  parameter int VL_MAX    = 64,
  parameter int REG_W     = 64,
  parameter int CR_BASE   = 32,
  parameter int CR_ADDR_W = 7,
  localparam int IDX_W    = $clog2(VL_MAX),
  localparam int N_LANES  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobesIn,
  input  logic [IDX_W-1:0]     idxIn,
  input  logic                 maskModeIn,
  input  logic [2:0]           dstCodeIn,
  input  logic [2:0]           srcCodeIn,
  input  logic                 twinIn,
  input  logic [REG_W-1:0]     r3In,
  input  logic [REG_W-1:0]     r10In,
  input  logic [REG_W-1:0]     r30In,
  input  logic [3:0]           crDataIn,
  output logic [CR_ADDR_W-1:0] crAddrOut,
  output logic                 dstEnOut,
  output logic                 srcEnOut
);

  localparam logic [CR_ADDR_W-1:0] CR_BASE_V = CR_ADDR_W'(CR_BASE);

  logic             modeReg;
  logic             twinReg;
  logic [2:0]       codeReg [N_LANES];
  logic [REG_W-1:0] r3Reg, r10Reg, r30Reg;
  logic [N_LANES-1:0] laneEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg    <= 1'b0;
      twinReg    <= 1'b0;
      codeReg[0] <= '0;
      codeReg[1] <= '0;
      r3Reg      <= '0;
      r10Reg     <= '0;
      r30Reg     <= '0;
    end else if (strobesIn.load) begin
      modeReg    <= maskModeIn;
      twinReg    <= twinIn;
      codeReg[0] <= dstCodeIn;
      codeReg[1] <= srcCodeIn;
      r3Reg      <= r3In;
      r10Reg     <= r10In;
      r30Reg     <= r30In;
    end
  end

  // Lane 0 = destination, lane 1 = source
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    predgen_lane #(.REG_W(REG_W), .IDX_W(IDX_W)) u_lane (
      .maskMode (modeReg),
      .code     (codeReg[g]),
      .regA     (r3Reg),
      .regB     (r10Reg),
      .regC     (r30Reg),
      .idx      (idxIn),
      .crField  (crDataIn),
      .enOut    (laneEn[g])
    );
  end

  always_comb begin
    crAddrOut = CR_BASE_V + {{(CR_ADDR_W-IDX_W){1'b0}}, idxIn};
    dstEnOut  = strobesIn.active && laneEn[0];
    srcEnOut  = strobesIn.active && (twinReg ? laneEn[1] : 1'b1);
  end

  // R1: integer mode with code zero enables every presented element
  p_no_pred_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobesIn.active && !modeReg && (codeReg[0] == 3'd0)) |-> dstEnOut);

  // R6: without twin predication the source is always enabled
  p_src_open_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobesIn.active && !twinReg) |-> srcEnOut);

  // R5: field address tracks the presented element
  p_cr_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobesIn.active |-> (crAddrOut == CR_BASE_V + CR_ADDR_W'(idxIn)));

  // R7: enables are quiet when nothing is presented
  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobesIn.active |-> (!dstEnOut && !srcEnOut));

  // R3: captured registers hold while no start is accepted
  p_regs_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobesIn.load |=> ($stable(r3Reg) && $stable(r10Reg) && $stable(r30Reg)));

endmodule

// File: rtl/vec_pred_gen.sv
module vec_pred_gen
  import predgen_pkg::*;
#(
  parameter int VL_MAX    = 64,
  parameter int REG_W     = 64,
  parameter int CR_BASE   = 32,
  parameter int CR_ADDR_W = 7,
  localparam int IDX_W    = $clog2(VL_MAX),
  localparam int VL_W     = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startIn,
  input  logic [VL_W-1:0]      vlIn,
  input  logic                 readyIn,
  input  logic                 maskModeIn,
  input  logic [2:0]           dstCodeIn,
  input  logic [2:0]           srcCodeIn,
  input  logic                 twinIn,
  input  logic [REG_W-1:0]     r3In,
  input  logic [REG_W-1:0]     r10In,
  input  logic [REG_W-1:0]     r30In,
  input  logic [3:0]           crDataIn,
  output logic [CR_ADDR_W-1:0] crAddrOut,
  output logic                 elemValidOut,
  output logic [IDX_W-1:0]     elemIdxOut,
  output logic                 dstEnOut,
  output logic                 srcEnOut,
  output logic                 doneOut,
  output logic                 busyOut
);

  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] idx;

  predgen_ctrl #(.VL_MAX(VL_MAX)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startIn      (startIn),
    .vlIn         (vlIn),
    .readyIn      (readyIn),
    .strobesOut   (strobes),
    .idxOut       (idx),
    .elemValidOut (elemValidOut),
    .doneOut      (doneOut),
    .busyOut      (busyOut)
  );

  predgen_dp #(
    .VL_MAX    (VL_MAX),
    .REG_W     (REG_W),
    .CR_BASE   (CR_BASE),
    .CR_ADDR_W (CR_ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobesIn  (strobes),
    .idxIn      (idx),
    .maskModeIn (maskModeIn),
    .dstCodeIn  (dstCodeIn),
    .srcCodeIn  (srcCodeIn),
    .twinIn     (twinIn),
    .r3In       (r3In),
    .r10In      (r10In),
    .r30In      (r30In),
    .crDataIn   (crDataIn),
    .crAddrOut  (crAddrOut),
    .dstEnOut   (dstEnOut),
    .srcEnOut   (srcEnOut)
  );

  assign elemIdxOut = idx;

endmodule

// File: tb/vec_pred_gen_test.sv
module vec_pred_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [6:0]  vlIn = '0;
  logic        readyIn = 1'b0;
  logic        maskModeIn = 1'b0;
  logic [2:0]  dstCodeIn = '0;
  logic [2:0]  srcCodeIn = '0;
  logic        twinIn = 1'b0;
  logic [63:0] r3In = '0, r10In = '0, r30In = '0;
  logic [3:0]  crDataIn;
  logic [6:0]  crAddrOut;
  logic        elemValidOut;
  logic [5:0]  elemIdxOut;
  logic        dstEnOut, srcEnOut, doneOut, busyOut;

  logic [3:0]  crBank [0:127];
  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign crDataIn = crBank[crAddrOut];

  vec_pred_gen uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .vlIn(vlIn), .readyIn(readyIn),
    .maskModeIn(maskModeIn), .dstCodeIn(dstCodeIn), .srcCodeIn(srcCodeIn),
    .twinIn(twinIn), .r3In(r3In), .r10In(r10In), .r30In(r30In),
    .crDataIn(crDataIn), .crAddrOut(crAddrOut), .elemValidOut(elemValidOut),
    .elemIdxOut(elemIdxOut), .dstEnOut(dstEnOut), .srcEnOut(srcEnOut),
    .doneOut(doneOut), .busyOut(busyOut)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference predicate, written arithmetically from the requirements
  function automatic bit refEn(input bit mode, input int code, input int i,
                               input logic [63:0] a, input logic [63:0] b,
                               input logic [63:0] c, input logic [3:0] cr);
    logic [63:0] src;
    int bitPos;
    if (mode) begin
      bitPos = 3 - (code / 2);
      return ((cr >> bitPos) & 4'h1) != 0 ? (code % 2 == 0) : (code % 2 == 1);
    end
    if (code == 0) return 1'b1;
    if (code == 1) return a == 64'(i);
    src = (code / 2 == 1) ? a : (code / 2 == 2) ? b : c;
    return ((src >> i) & 64'h1) != 0 ? (code % 2 == 0) : (code % 2 == 1);
  endfunction

  task automatic runLoop(input int vl, input bit mode, input int dc, input int sc,
                         input bit twin, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] c, input int readyPat,
                         input bit strayMid, input bit strayDone, input bit flipCr);
    int expIdx = 0;
    int cyc = 0;
    bit rdy;
    @(negedge clk);
    vlIn = 7'(vl); maskModeIn = mode; dstCodeIn = 3'(dc); srcCodeIn = 3'(sc);
    twinIn = twin; r3In = a; r10In = b; r30In = c; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    // scramble configuration inputs: the running loop must not see them (R3)
    r3In = ~a; r10In = ~b; r30In = ~c; maskModeIn = ~mode;
    dstCodeIn = ~3'(dc); srcCodeIn = ~3'(sc); twinIn = ~twin; vlIn = 7'd3;
    while (expIdx < vl) begin
      if (flipCr && cyc == 0) crBank[32 + vl - 1] = ~crBank[32 + vl - 1];  // R5 lazy read
      check("R7 elemValid", longint'(elemValidOut), 1);
      check("R7 index", longint'(elemIdxOut), expIdx);
      check("R9 busy while running", longint'(busyOut), 1);
      check("R9 no early done", longint'(doneOut), 0);
      check("R5 field address", longint'(crAddrOut), 32 + expIdx);
      check(mode ? "R4 dst enable" : "R1 R2 R3 dst enable", longint'(dstEnOut),
            longint'(refEn(mode, dc, expIdx, a, b, c, crBank[32 + expIdx])));
      check("R6 src enable", longint'(srcEnOut),
            twin ? longint'(refEn(mode, sc, expIdx, a, b, c, crBank[32 + expIdx])) : 1);
      rdy = (readyPat == 0) ? 1'b1 : ((cyc % 3) != 1);
      readyIn = rdy;
      startIn = strayMid && (cyc == 1 || cyc == 2);  // R10 stray starts
      cyc++;
      @(negedge clk);
      startIn = 1'b0;
      if (rdy) expIdx++;
    end
    check("R9 done pulse", longint'(doneOut), 1);
    check("R9 busy in done", longint'(busyOut), 1);
    check("R8 no element at done", longint'(elemValidOut), 0);
    check("R7 quiet enables", longint'({dstEnOut, srcEnOut}), 0);
    startIn = strayDone;
    @(negedge clk);
    startIn = 1'b0;
    check("R9 done one cycle", longint'(doneOut), 0);
    check("R9 busy low after done", longint'(busyOut), 0);
    @(negedge clk);
    check("R10 start at done ignored", longint'(busyOut), 0);
    readyIn = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 128; k++) crBank[k] = 4'((k * 5 + 3) ^ (k >> 2));
    repeat (3) @(negedge clk);
    check("reset busy", longint'(busyOut), 0);
    check("reset done", longint'(doneOut), 0);
    check("reset valid", longint'(elemValidOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: no predication
    runLoop(5, 0, 0, 0, 0, 64'h0, 64'h0, 64'h0, 0, 0, 0, 0);
    // R2: single element, plus out-of-range index
    runLoop(8, 0, 1, 2, 1, 64'd6, 64'h0, 64'h0, 0, 0, 0, 0);
    runLoop(8, 0, 1, 0, 0, 64'd100, 64'h0, 64'h0, 1, 0, 0, 0);
    // R3: register masks with stalls and stray starts
    runLoop(64, 0, 3, 4, 1, 64'hF0E1_D2C3_B4A5_9687, 64'h0123_4567_89AB_CDEF,
            64'h5555_AAAA_3333_CCCC, 1, 1, 1, 0);
    runLoop(20, 0, 5, 6, 1, 64'h1, 64'hDEAD_BEEF_0BAD_F00D, 64'h8000_0000_FFFF_0001,
            1, 0, 0, 0);
    runLoop(33, 0, 7, 2, 1, 64'hA5A5_0000_FFFF_1234, 64'h0, 64'h7777_8888_9999_0000,
            0, 1, 0, 0);
    // R4, R5, R6: every condition code, lazy read of the bank
    for (int cd = 0; cd < 8; cd++)
      runLoop(12 + cd, 1, cd, 7 - cd, cd % 2 == 0, 64'h0, 64'h0, 64'h0,
              cd % 2, cd == 3, cd == 5, 1);
    // R8: zero-length loop, with a stray start at done
    runLoop(0, 0, 2, 0, 1, 64'hFF, 64'h0, 64'h0, 0, 0, 1, 0);
    runLoop(0, 1, 4, 0, 0, 64'h0, 64'h0, 64'h0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule